// File: doc/BRIEF.md
# Gated Retriggerable Digital One-Shot

This block is a clocked monostable pulse generator. A qualified edge on one of its two trigger inputs starts an output pulse. The pulse lasts a programmed number of clock cycles, however long the trigger input is then held. The width comes from a cycle counter rather than from a resistor-capacitor network, so it is exact and can be changed at run time through a width port.

There are two trigger inputs of opposite polarity, and each gates the other. The active-low trigger fires on its falling edge, but only while the active-high trigger is high. The active-high trigger fires on its rising edge, but only while the active-low trigger is low. An active-low clear forces the outputs idle and cuts a running pulse short at once.

Two mode inputs set the remaining behaviour:
- A retrigger mode makes a new trigger during a pulse restart the full width. With it off, such a trigger is ignored.
- A clear-start mode lets the release of clear start a pulse while both trigger inputs sit in their armed levels.

All inputs are synchronous to one clock. Edges are found by comparing each input with its value in the previous cycle.

Top module: `gated_oneshot`

## Requirements
- R1: A falling edge on trig_a_n while trig_b is high and clr_n is high makes pulse high from the next clock cycle on.
- R2: A rising edge on trig_b while trig_a_n is low and clr_n is high makes pulse high from the next clock cycle on.
- R3: While clr_n is low, pulse is low in the same cycle, without waiting for a clock edge. A running pulse is ended, and no trigger edge is accepted.
- R4: No pulse starts while trig_a_n is held high or trig_b is held low.
- R5: pulse_n is always the inverse of pulse.
- R6: A started pulse stays high for exactly width clock cycles, whatever the trigger inputs do during it, as long as no retrigger is accepted.
- R7: With retrig_en high, a valid trigger during a pulse reloads the full width, so pulse ends width cycles after the last trigger.
- R8: With retrig_en low, triggers during a pulse are ignored and the pulse ends width cycles after it started.
- R9: With clr_start_en high, a rising edge on clr_n while trig_a_n is low and trig_b is high starts a pulse. With clr_start_en low, releasing clr_n never starts one.
- R10: A width value of 0 gives a pulse of one cycle.
- R11: After reset, pulse is low, pulse_n is high and the cycle counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_a_n | input | 1 | Active-low trigger; fires on its falling edge |
| trig_b | input | 1 | Active-high trigger; fires on its rising edge |
| clr_n | input | 1 | Active-low clear; ends any pulse |
| width | input | CNT_W | Pulse width in clock cycles (0 counts as 1) |
| retrig_en | input | 1 | 1: a trigger during a pulse restarts it; 0: such a trigger is ignored |
| clr_start_en | input | 1 | 1: release of clear may start a pulse |
| pulse | output | 1 | True output |
| pulse_n | output | 1 | Complementary output |

## Verification
The bench builds the block with the default 16-bit counter. It programs widths of 0, 1, 3 and 300. The width of 3 leaves room to land a trigger in the middle of a pulse, in both retrigger settings. The width of 300 carries the count past the low byte, so a borrow from the upper counter bits is exercised. Clear is asserted mid-pulse and then released with the trigger inputs armed, first with the clear-start mode off and then with it on. This shows that the mode alone decides whether the release of clear starts a pulse.

// File: rtl/gated_oneshot.sv
`timescale 1ns/1ps
module gated_oneshot #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_a_n,
  input  logic             trig_b,
  input  logic             clr_n,
  input  logic [CNT_W-1:0] width,
  input  logic             retrig_en,
  input  logic             clr_start_en,
  output logic             pulse,
  output logic             pulse_n
);

  logic             a_q, b_q, c_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load_val;
  logic             edge_trig, clr_trig, start, accept, active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b1;
      b_q <= 1'b0;
      c_q <= 1'b1;
    end else begin
      a_q <= trig_a_n;
      b_q <= trig_b;
      c_q <= clr_n;
    end
  end

  assign edge_trig = clr_n & ((a_q & ~trig_a_n & trig_b) | (~b_q & trig_b & ~trig_a_n));
  assign clr_trig  = clr_start_en & ~c_q & clr_n & ~trig_a_n & trig_b;
  assign start     = edge_trig | clr_trig;
  assign active    = (cnt != '0);
  assign accept    = start & (~active | retrig_en);
  assign load_val  = (width == '0) ? CNT_W'(1) : width;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!clr_n) cnt <= '0;
    else if (accept) cnt <= load_val;
    else if (active) cnt <= cnt - 1'b1;
  end

  assign pulse   = active & clr_n;
  assign pulse_n = ~pulse;

  p_comp_r5: assert property (@(posedge clk) disable iff (!rst_n) pulse_n == !pulse);
  p_clr_idle_r3: assert property (@(posedge clk) disable iff (!rst_n) !clr_n |-> !pulse);
  p_clr_cut_r3: assert property (@(posedge clk) disable iff (!rst_n) !clr_n |=> cnt == '0);
  p_fall_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && a_q && !trig_a_n && trig_b) |=> pulse || !clr_n);
  p_rise_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !b_q && trig_b && !trig_a_n) |=> pulse || !clr_n);
  p_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !trig_b) |=> !pulse);
  p_no_retrig_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!retrig_en && active && clr_n) |=> cnt == $past(cnt) - 1'b1);
  p_min_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && clr_n && width == '0) |=> cnt == CNT_W'(1));

endmodule

// File: tb/tb_gated_oneshot.sv
`timescale 1ns/1ps
module tb_gated_oneshot;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        a_n = 1, b = 0, c_n = 1;
  logic [15:0] w = 16'd3;
  logic        retrig = 0, cstart = 0;
  logic        q, qn;
  int          checks = 0, fails = 0;
  bit          exp_q[$];
  string       tag_q[$];
  bit          done = 0;

  gated_oneshot dut (.clk(clk), .rst_n(rst_n), .trig_a_n(a_n), .trig_b(b), .clr_n(c_n),
    .width(w), .retrig_en(retrig), .clr_start_en(cstart), .pulse(q), .pulse_n(qn));

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic cyc(input bit a, input bit bb, input bit c, input bit e, input string tag);
    @(negedge clk);
    a_n = a; b = bb; c_n = c;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic run(input int n, input bit a, input bit bb, input bit c, input bit e, input string tag);
    for (int i = 0; i < n; i++) cyc(a, bb, c, e, tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      automatic bit    e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      check(q == e, t, q, e);
      check(qn == !q, "R5 complement", qn, !q);
    end
  end

  initial begin
    #800000;
    check(0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(q == 0 && qn == 1, "R11 reset idle", q, 0);
    rst_n = 1;
    @(negedge clk);
    check(q == 0, "R11 idle after reset", q, 0);
    // R1 falling edge of A with B high; held input does not stretch (R6)
    cyc(1,1,1,0,"R1 setup");
    cyc(0,1,1,1,"R1 start");
    run(2,0,1,1,1,"R6 width");
    run(2,0,1,1,0,"R6 end despite held input");
    cyc(1,1,1,0,"R1 A release");
    // R2 rising edge of B with A low
    cyc(0,0,1,0,"R2 setup");
    cyc(0,1,1,1,"R2 start");
    run(2,0,1,1,1,"R2 width");
    cyc(0,1,1,0,"R2 end");
    // R4 blocked gating
    cyc(1,0,1,0,"R4 setup");
    cyc(0,0,1,0,"R4 A falls with B low");
    cyc(1,0,1,0,"R4 setup2");
    cyc(1,1,1,0,"R4 B rises with A high");
    // R3 no trigger while clear low; R9 release with mode off
    cyc(1,1,0,0,"R3 clear");
    cyc(0,1,0,0,"R3 edge during clear");
    cyc(0,1,1,0,"R9 release mode off");
    cyc(1,1,1,0,"idle");
    // R8 non-retriggerable
    cyc(0,1,1,1,"R8 start");
    cyc(1,1,1,1,"R8 mid");
    cyc(0,1,1,1,"R8 trigger ignored");
    cyc(1,1,1,0,"R8 ends on time");
    cyc(1,1,1,0,"R8 idle");
    // R7 retriggerable
    retrig = 1;
    cyc(0,1,1,1,"R7 start");
    cyc(1,1,1,1,"R7 mid");
    cyc(0,1,1,1,"R7 retrigger");
    run(2,1,1,1,1,"R7 extended");
    cyc(1,1,1,0,"R7 end");
    retrig = 0;
    // R3 clear cuts a running pulse, immediate
    cyc(0,1,1,1,"R3 start");
    cyc(0,1,1,1,"R3 running");
    @(negedge clk);
    c_n = 0;
    #1 check(q == 0, "R3 immediate cut", q, 0);
    check(qn == 1, "R3 complement during clear", qn, 1);
    exp_q.push_back(0); tag_q.push_back("R3 cut");
    cyc(0,1,1,0,"R9 release off after cut");
    cyc(1,1,1,0,"idle");
    // R9 clear-start mode
    cstart = 1;
    cyc(0,1,0,0,"R9 hold clear");
    cyc(0,1,1,1,"R9 clear release starts");
    run(2,0,1,1,1,"R9 width");
    cyc(0,1,1,0,"R9 end");
    cyc(0,0,0,0,"R9 B low");
    cyc(0,0,1,0,"R9 B low blocks");
    cstart = 0;
    // R10 width zero and one
    cyc(1,1,1,0,"R10 setup");
    w = 16'd0;
    cyc(0,1,1,1,"R10 width0 one cycle");
    cyc(0,1,1,0,"R10 width0 end");
    cyc(1,1,1,0,"R10 setup");
    w = 16'd1;
    cyc(0,1,1,1,"R10 width1");
    cyc(0,1,1,0,"R10 width1 end");
    // R6 long width
    cyc(1,1,1,0,"R6 setup");
    w = 16'd300;
    cyc(0,1,1,1,"R6 long start");
    run(299,0,1,1,1,"R6 long");
    cyc(0,1,1,0,"R6 long end");
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule